// File: doc/BRIEF.md
# Software Write-Protect Command Detector

This block sits beside the write path of a paged non-volatile memory model. It watches each byte-load strobe and its address and data, and recognizes two fixed unlock sequences. A three-write sequence arms software write protection. A six-write sequence disarms it. Each byte that fits the next expected step of a sequence is flagged as a command byte, so the write sequencer must not store it. A byte that breaks a sequence is ordinary data.

At the start of each program period the block tells the write sequencer whether that page load may reach the array. When protection is on, a load goes to the array only if a complete sequence came before its data in the same load window. A load without the sequence still runs a full program period, but the commit enable is low, so nothing is stored. A protection change takes effect only at the end of the program period that follows the sequence. This holds even when no data bytes follow the sequence. The protection flag is modelled as a register that reset does not touch, so it survives power transitions.

Only the low 15 address bits are compared. Command writes must meet page-load timing: a byte-load timeout tick ends the load window and abandons any partial sequence.

Top module: `sdp_cmd_detector`

## Requirements
- R1: After reset, `cmd_byte` is 0 and `commit_en` is 1.
- R2: `prot_on` is 0 from time zero. Asserting `rst` does not change it.
- R3: Three writes in order arm protection: 8'hAA at 15'h5555, then 8'h55 at 15'h2AAA, then 8'hA0 at 15'h5555. Each of the three bytes raises `cmd_byte` in the cycle after its strobe. `prot_on` becomes 1 at the next `prog_done`, even with no data bytes in that load.
- R4: Six writes in order disarm protection: AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555. Each raises `cmd_byte`, and `prot_on` becomes 0 at the next `prog_done`.
- R5: Only the low 15 bits of `wr_addr` are compared. Any value of the upper bits still matches.
- R6: A write whose address/data pair does not fit the expected step returns the matcher to idle. That write is ordinary data (`cmd_byte` stays 0), and the sequence does not resume from where it broke off.
- R7: A `load_tmo` tick returns the matcher to idle. Bytes that would have completed the sequence after the tick are ordinary data.
- R8: While `prot_on` is 1, a load with no complete sequence drives `commit_en` to 0 at its `load_tmo`.
- R9: While `prot_on` is 1, a load that begins with a complete sequence drives `commit_en` to 1 at its `load_tmo`. Its data bytes, including ones at the key addresses, are not command bytes.
- R10: While `prot_on` is 0, every `load_tmo` drives `commit_en` to 1.
- R11: `prot_on` changes only in the cycle after `prog_done`. `commit_en` changes only in the cycle after `load_tmo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (leaves protection unchanged) |
| wr_stb | input | 1 | One-cycle byte-load strobe |
| wr_addr | input | FULL_ADDR_W (19) | Byte address of the load |
| wr_data | input | DATA_W (8) | Byte data of the load |
| load_tmo | input | 1 | Byte-load window expired; the program period begins |
| prog_done | input | 1 | End of the program period |
| prot_on | output | 1 | Software write protection active |
| commit_en | output | 1 | Current program period may store its page |
| cmd_byte | output | 1 | The previous cycle's strobed byte was a command byte |

## Verification
A matcher stuck at the wrong step shows up one cycle after the next strobe. `cmd_byte` then rises on a byte that breaks the sequence, or stays low on one that fits it. A lost or false unlock shows up at the next `load_tmo` as the wrong `commit_en` level. A wrong pending request shows up only one cycle after the following `prog_done`, as a wrong `prot_on`. For that reason each scenario closes its program period and reads `prot_on` before the next one starts.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int KEY_AW = 15;
  localparam int KEY_DW = 8;

  localparam logic [KEY_AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_AW-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [KEY_DW-1:0] KEY_D1     = 8'hAA;
  localparam logic [KEY_DW-1:0] KEY_D2     = 8'h55;
  localparam logic [KEY_DW-1:0] OP_ARM     = 8'hA0;
  localparam logic [KEY_DW-1:0] OP_PREFIX  = 8'h80;
  localparam logic [KEY_DW-1:0] OP_DISARM  = 8'h20;

  // Name of the step the matcher expects next
  typedef enum logic [2:0] {
    EXP_K1,   // first key byte
    EXP_K2,   // second key byte
    EXP_OP,   // arm opcode or disarm prefix
    EXP_K4,   // disarm: first key byte again
    EXP_K5,   // disarm: second key byte again
    EXP_FIN   // disarm opcode
  } step_e;
endpackage

// File: rtl/sdp_seq_matcher.sv
module sdp_seq_matcher
  import sdp_pkg::*;
#(
  parameter int CMP_ADDR_W = 15,
  parameter int DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  logic                  abort,
  input  logic [CMP_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     data,
  output logic                  arm_hit,
  output logic                  disarm_hit,
  output logic                  cmd_q
);
  step_e step_q, step_nxt;
  logic  fits;
  logic  at_a, at_b;

  assign at_a = (addr == CMP_ADDR_W'(KEY_ADDR_A));
  assign at_b = (addr == CMP_ADDR_W'(KEY_ADDR_B));

  always_comb begin
    step_nxt   = EXP_K1;
    fits       = 1'b0;
    arm_hit    = 1'b0;
    disarm_hit = 1'b0;
    unique case (step_q)
      EXP_K1: if (at_a && data == DATA_W'(KEY_D1)) begin
        fits = 1'b1; step_nxt = EXP_K2;
      end
      EXP_K2: if (at_b && data == DATA_W'(KEY_D2)) begin
        fits = 1'b1; step_nxt = EXP_OP;
      end
      EXP_OP: if (at_a && data == DATA_W'(OP_ARM)) begin
        fits = 1'b1; arm_hit = wr_stb && !abort;
      end else if (at_a && data == DATA_W'(OP_PREFIX)) begin
        fits = 1'b1; step_nxt = EXP_K4;
      end
      EXP_K4: if (at_a && data == DATA_W'(KEY_D1)) begin
        fits = 1'b1; step_nxt = EXP_K5;
      end
      EXP_K5: if (at_b && data == DATA_W'(KEY_D2)) begin
        fits = 1'b1; step_nxt = EXP_FIN;
      end
      EXP_FIN: if (at_a && data == DATA_W'(OP_DISARM)) begin
        fits = 1'b1; disarm_hit = wr_stb && !abort;
      end
      default: step_nxt = EXP_K1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      step_q <= EXP_K1;
      cmd_q  <= 1'b0;
    end else if (wr_stb) begin
      step_q <= step_nxt;
      cmd_q  <= fits;
    end else begin
      cmd_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/sdp_prot_state.sv
module sdp_prot_state (
  input  logic clk,
  input  logic rst,
  input  logic arm_hit,
  input  logic disarm_hit,
  input  logic load_tmo,
  input  logic prog_done,
  output logic prot_on,
  output logic commit_en
);
  logic prot_q = 1'b0;
  logic pend_arm_q, pend_disarm_q, unlocked_q, commit_q;

  // Kept across reset: models state that survives power transitions
  always_ff @(posedge clk) begin
    if (prog_done) begin
      if (pend_arm_q)         prot_q <= 1'b1;
      else if (pend_disarm_q) prot_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_arm_q    <= 1'b0;
      pend_disarm_q <= 1'b0;
      unlocked_q    <= 1'b0;
      commit_q      <= 1'b1;
    end else begin
      if (arm_hit) begin
        pend_arm_q    <= 1'b1;
        pend_disarm_q <= 1'b0;
      end else if (disarm_hit) begin
        pend_arm_q    <= 1'b0;
        pend_disarm_q <= 1'b1;
      end else if (prog_done) begin
        pend_arm_q    <= 1'b0;
        pend_disarm_q <= 1'b0;
      end
      if (load_tmo) begin
        commit_q   <= !prot_q || unlocked_q || arm_hit || disarm_hit;
        unlocked_q <= 1'b0;
      end else if (arm_hit || disarm_hit) begin
        unlocked_q <= 1'b1;
      end
    end
  end

  assign prot_on   = prot_q;
  assign commit_en = commit_q;
endmodule

// File: rtl/sdp_cmd_detector.sv
module sdp_cmd_detector #(
  parameter int FULL_ADDR_W = 19,
  parameter int CMP_ADDR_W  = 15,
  parameter int DATA_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_stb,
  input  logic [FULL_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   load_tmo,
  input  logic                   prog_done,
  output logic                   prot_on,
  output logic                   commit_en,
  output logic                   cmd_byte
);
  logic arm_hit, disarm_hit;

  sdp_seq_matcher #(.CMP_ADDR_W(CMP_ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .abort      (load_tmo),
    .addr       (wr_addr[CMP_ADDR_W-1:0]),
    .data       (wr_data),
    .arm_hit    (arm_hit),
    .disarm_hit (disarm_hit),
    .cmd_q      (cmd_byte)
  );

  sdp_prot_state u_prot (
    .clk        (clk),
    .rst        (rst),
    .arm_hit    (arm_hit),
    .disarm_hit (disarm_hit),
    .load_tmo   (load_tmo),
    .prog_done  (prog_done),
    .prot_on    (prot_on),
    .commit_en  (commit_en)
  );
endmodule

// File: rtl/sdp_cmd_detector_chk.sv
module sdp_cmd_detector_chk (
  input logic clk,
  input logic rst,
  input logic wr_stb,
  input logic load_tmo,
  input logic prog_done,
  input logic prot_on,
  input logic commit_en,
  input logic cmd_byte
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (commit_en && !cmd_byte));

  assert_prot_at_done_R11: assert property (@(posedge clk) disable iff (rst)
    !prog_done |=> $stable(prot_on));

  assert_commit_at_tmo_R11: assert property (@(posedge clk) disable iff (rst)
    !load_tmo |=> $stable(commit_en));

  assert_cmd_needs_stb_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> !cmd_byte);

  assert_open_commit_R10: assert property (@(posedge clk) disable iff (rst)
    (load_tmo && !prot_on) |=> commit_en);
endmodule

bind sdp_cmd_detector sdp_cmd_detector_chk u_chk (.*);

// File: tb/tb_sdp_cmd_detector.sv
`timescale 1ns/1ps
module tb_sdp_cmd_detector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        load_tmo = 1'b0;
  logic        prog_done = 1'b0;
  logic        prot_on, commit_en, cmd_byte;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdp_cmd_detector dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_tmo(load_tmo), .prog_done(prog_done),
    .prot_on(prot_on), .commit_en(commit_en), .cmd_byte(cmd_byte)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d,
                    input logic exp_cmd, input string req);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(req, cmd_byte, exp_cmd);
  endtask

  task automatic tmo(input logic exp_commit, input string req);
    @(negedge clk); load_tmo = 1'b1;
    @(negedge clk); load_tmo = 1'b0;
    chk(req, commit_en, exp_commit);
  endtask

  task automatic done(input logic exp_prot, input string req);
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
    chk(req, prot_on, exp_prot);
  endtask

  task automatic arm_seq(input string req);
    wr(19'h05555, 8'hAA, 1'b1, req);
    wr(19'h02AAA, 8'h55, 1'b1, req);
    wr(19'h05555, 8'hA0, 1'b1, req);
  endtask

  task automatic t_reset;
    chk("R2 initial prot", prot_on, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 cmd_byte", cmd_byte, 1'b0);
    chk("R1 commit_en", commit_en, 1'b1);
    chk("R2 prot after reset", prot_on, 1'b0);
  endtask

  task automatic t_plain_open;
    wr(19'h00123, 8'h42, 1'b0, "R10 plain byte");
    tmo(1'b1, "R10 open commit");
    done(1'b0, "R10 prot stays off");
  endtask

  task automatic t_arm;
    wr(19'h75555, 8'hAA, 1'b1, "R5 upper bits ignored");
    wr(19'h42AAA, 8'h55, 1'b1, "R3 step2");
    wr(19'h05555, 8'hA0, 1'b1, "R3 step3");
    chk("R11 prot before done", prot_on, 1'b0);
    tmo(1'b1, "R3 commit");
    chk("R11 prot after tmo", prot_on, 1'b0);
    done(1'b1, "R3 armed at done");
  endtask

  task automatic t_locked_plain;
    wr(19'h00100, 8'h33, 1'b0, "R8 plain byte");
    tmo(1'b0, "R8 blocked");
    done(1'b1, "R8 prot kept");
  endtask

  task automatic t_reset_keeps;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R2 prot survives reset", prot_on, 1'b1);
    chk("R1 commit after reset", commit_en, 1'b1);
  endtask

  task automatic t_unlocked;
    arm_seq("R9 sequence");
    wr(19'h05555, 8'h77, 1'b0, "R9 data at key addr");
    wr(19'h02AAA, 8'h55, 1'b0, "R9 key data as data");
    tmo(1'b1, "R9 commit");
    done(1'b1, "R9 prot kept");
  endtask

  task automatic t_mismatch;
    wr(19'h05555, 8'hAA, 1'b1, "R6 first fits");
    wr(19'h02AAA, 8'h56, 1'b0, "R6 mismatch is data");
    wr(19'h05555, 8'hA0, 1'b0, "R6 no resume");
    tmo(1'b0, "R6 no unlock");
    done(1'b1, "R6 prot kept");
  endtask

  task automatic t_timeout;
    wr(19'h05555, 8'hAA, 1'b1, "R7 step1");
    wr(19'h02AAA, 8'h55, 1'b1, "R7 step2");
    tmo(1'b0, "R7 partial no unlock");
    done(1'b1, "R7 prot kept");
    wr(19'h05555, 8'hA0, 1'b0, "R7 after abort");
    tmo(1'b0, "R7 still blocked");
    done(1'b1, "R7 prot kept 2");
  endtask

  task automatic t_disarm;
    wr(19'h05555, 8'hAA, 1'b1, "R4 s1");
    wr(19'h02AAA, 8'h55, 1'b1, "R4 s2");
    wr(19'h05555, 8'h80, 1'b1, "R4 s3");
    wr(19'h05555, 8'hAA, 1'b1, "R4 s4");
    wr(19'h02AAA, 8'h55, 1'b1, "R4 s5");
    wr(19'h05555, 8'h20, 1'b1, "R4 s6");
    chk("R11 prot before done", prot_on, 1'b1);
    tmo(1'b1, "R4 commit");
    done(1'b0, "R4 disarmed at done");
    wr(19'h00200, 8'h11, 1'b0, "R10 plain after disarm");
    tmo(1'b1, "R10 commit after disarm");
    done(1'b0, "R10 prot off");
  endtask

  initial begin
    t_reset();
    t_plain_open();
    t_arm();
    t_locked_plain();
    t_reset_keeps();
    t_unlocked();
    t_mismatch();
    t_timeout();
    t_disarm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule